// File: doc/BRIEF.md
# Filtered Reset Conditioner

This block turns a noisy, active-high external reset request into a clean active-high reset for a single clock domain. The raw request first crosses into the clock domain through a short flop chain. A run-length filter then accepts it only once it has been seen on a programmable number of consecutive clock edges; anything shorter leaves no trace on the reset output. An accepted request loads a self-timed stretch counter, so the reset stays on for a fixed number of cycles after the last qualifying cycle, whether or not the source is still driving. Reset is set asynchronously from that counter and released through a two-flop chain, so deassertion always lands cleanly on a clock edge.

A second path protects outputs of the logic being reset. While the raw request is high, and for a short time after it drops, the guarded output bus is forced to a fixed reset pattern combinationally, with no clock involved. The force lifts once the request has drained out of the input synchronizer. For an accepted request the reset output has then been on for at least one full cycle, so the core already drives the same values. Outside these windows the bus passes through unchanged. The bus is a plain combinational pass-through with no valid/ready handshake, so it never applies back-pressure. Every register powers up in the reset-asserted state, so the reset output is active from time zero until a first full stretch has run out.

Top module: `rstc_top`

## Requirements
- R1: From power-up with no request, `rst_o` is 1 from time zero and falls at clock edge STRETCH+4, counting the first rising edge as edge 1.
- R2: A request sampled high on fewer than MIN_PULSE consecutive rising edges is ignored. `rst_o` stays 0, and so does a request that is high only between two edges.
- R3: `rst_o` is active high. For a request first sampled high at edge k and held for N >= MIN_PULSE edges, `rst_o` rises just after edge k+MIN_PULSE+1, set asynchronously by the stretch counter.
- R4: Release is counted from the last qualifying cycle: STRETCH cycles in the counter, then two release flops. For an isolated request, `rst_o` falls at edge k+N+STRETCH+3.
- R5: A new request that qualifies while a stretch is running reloads the counter. `rst_o` then stays 1 without a gap until STRETCH+3 edges after the new request's last sampled edge.
- R6: Each assertion of `rst_o` lasts at least one full cycle. For an isolated accepted request it lasts exactly N-MIN_PULSE+STRETCH+2 cycles.
- R7: While `req_raw_i` is 1, `clamp_q_o` equals CLAMP_VAL (bench: 8'hA5) combinationally, with no clock edge needed.
- R8: After the request drops, the clamp holds until edge k+N+2, when both synchronizer flops have read it low. For an accepted request `rst_o` has then been 1 for at least one cycle. A request high only between two edges is released at the next edge.
- R9: When the clamp is not active, `clamp_q_o` equals `core_q_i` bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock of the domain being reset |
| req_raw_i | input | 1 | Raw asynchronous reset request, active high |
| core_q_i | input | DATA_W | Outputs of the logic being reset, before clamping |
| rst_o | output | 1 | Conditioned reset, active high, synchronous release |
| clamp_q_o | output | DATA_W | Guarded outputs: CLAMP_VAL while clamped, else `core_q_i` |

## Verification
A run counter that is off by one moves the rising edge of `rst_o` by a cycle, or turns a rejected pulse of MIN_PULSE-1 edges into a full reset; both show within MIN_PULSE+2 edges of the request. A wrong stretch load, a wrong reload or a missing release flop shifts the falling edge of `rst_o`. This shows after STRETCH+3 edges as a pulse of the wrong length, or as a gap in the restart case. A clamp that clears too early or too late changes `clamp_q_o` against a core pattern that changes every cycle, so it shows on the first edge after the expected release.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // Bits needed to hold 0..max_val, never less than one.
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o,
  output logic busy_o
);
  localparam int LAST = STAGES - 1;

  // Powers up holding the request level so the reset starts asserted.
  logic [LAST:0] stg_q = {STAGES{INIT}};

  always_ff @(posedge clk_i) begin
    stg_q <= {stg_q[LAST-1:0], d_i};
  end

  assign q_o    = stg_q[LAST];
  // Any stage still high means a request is in flight.
  assign busy_o = |stg_q;
endmodule

// File: rtl/rstc_qual_filter.sv
module rstc_qual_filter #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk_i,
  input  logic req_i,
  output logic qual_o
);
  localparam int CW = rstc_pkg::cnt_width(MIN_PULSE - 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_PULSE - 1);

  // Number of earlier consecutive high cycles, saturating at MIN_PULSE-1.
  logic [CW-1:0] run_q = SAT;

  always_ff @(posedge clk_i) begin
    if (!req_i) begin
      run_q <= '0;
    end else if (run_q != SAT) begin
      run_q <= run_q + 1'b1;
    end
  end

  // High on the MIN_PULSE-th consecutive high cycle and while it lasts.
  assign qual_o = req_i && (run_q == SAT);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int STRETCH    = 6,
  parameter int REL_STAGES = 2
) (
  input  logic clk_i,
  input  logic load_i,
  output logic hold_o,
  output logic rst_o
);
  localparam int SW   = rstc_pkg::cnt_width(STRETCH);
  localparam int RTOP = REL_STAGES - 1;
  localparam logic [SW-1:0] LOAD = SW'(STRETCH);

  logic [SW-1:0]   left_q = LOAD;
  logic [RTOP:0]   rel_q  = '1;

  // Self-timed hold: reloads on every qualifying cycle, then counts out.
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign hold_o = (left_q != '0);

  // Set at once while holding, release walks through the chain on edges.
  always_ff @(posedge clk_i or posedge hold_o) begin
    if (hold_o) begin
      rel_q <= '1;
    end else begin
      rel_q <= {rel_q[RTOP-1:0], 1'b0};
    end
  end

  assign rst_o = rel_q[RTOP];
endmodule

// File: rtl/rstc_out_clamp.sv
module rstc_out_clamp #(
  parameter int               DATA_W    = 8,
  parameter bit               ENABLE    = 1'b1,
  parameter logic [DATA_W-1:0] CLAMP_VAL = '0
) (
  input  logic              clk_i,
  input  logic              raw_i,
  input  logic              drained_i,
  input  logic [DATA_W-1:0] core_i,
  output logic [DATA_W-1:0] clamp_o,
  output logic              active_o
);
  generate
    if (ENABLE) begin : g_clamp
      logic keep_q = 1'b1;

      // Set by the raw request itself, cleared on an edge once drained.
      always_ff @(posedge clk_i or posedge raw_i) begin
        if (raw_i) begin
          keep_q <= 1'b1;
        end else if (drained_i) begin
          keep_q <= 1'b0;
        end
      end

      assign active_o = raw_i | keep_q;
      assign clamp_o  = active_o ? CLAMP_VAL : core_i;
    end else begin : g_pass
      assign active_o = 1'b0;
      assign clamp_o  = core_i;
    end
  endgenerate
endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
  parameter int                MIN_PULSE  = 4,
  parameter int                STRETCH    = 6,
  parameter int                REQ_SYNC   = 2,
  parameter int                REL_SYNC   = 2,
  parameter int                DATA_W     = 8,
  parameter bit                CLAMP_EN   = 1'b1,
  parameter logic [DATA_W-1:0] CLAMP_VAL  = '0
) (
  input  logic              clk_i,
  input  logic              req_raw_i,
  input  logic [DATA_W-1:0] core_q_i,
  output logic              rst_o,
  output logic [DATA_W-1:0] clamp_q_o
);
  logic req_sync;
  logic req_busy;
  logic req_qual;
  logic stretch_hold;
  logic clamp_active;

  rstc_sync #(
    .STAGES (REQ_SYNC),
    .INIT   (1'b1)
  ) req_sync_i (
    .clk_i  (clk_i),
    .d_i    (req_raw_i),
    .q_o    (req_sync),
    .busy_o (req_busy)
  );

  rstc_qual_filter #(
    .MIN_PULSE (MIN_PULSE)
  ) qual_i (
    .clk_i  (clk_i),
    .req_i  (req_sync),
    .qual_o (req_qual)
  );

  rstc_stretch #(
    .STRETCH    (STRETCH),
    .REL_STAGES (REL_SYNC)
  ) stretch_i (
    .clk_i  (clk_i),
    .load_i (req_qual),
    .hold_o (stretch_hold),
    .rst_o  (rst_o)
  );

  rstc_out_clamp #(
    .DATA_W    (DATA_W),
    .ENABLE    (CLAMP_EN),
    .CLAMP_VAL (CLAMP_VAL)
  ) clamp_i (
    .clk_i     (clk_i),
    .raw_i     (req_raw_i),
    .drained_i (!req_busy),
    .core_i    (core_q_i),
    .clamp_o   (clamp_q_o),
    .active_o  (clamp_active)
  );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int                W         = 8,
  parameter bit                CLAMP_EN  = 1'b1,
  parameter logic [W-1:0]      CLAMP_VAL = '0
) (
  input logic         clk_i,
  input logic         req_raw_i,
  input logic         rst_o,
  input logic [W-1:0] clamp_q_o,
  input logic         hold_w,
  input logic         clamp_act_w
);
  logic [1:0] age_q = '0;
  logic       armed;

  always_ff @(posedge clk_i) begin
    if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  // R2
  qual_len_chk: assert property (@(posedge clk_i) disable iff (!armed)
    $rose(rst_o) |-> $past(req_raw_i, 3));

  // R4
  rel_chain_chk: assert property (@(posedge clk_i) disable iff (!armed)
    $fell(rst_o) |-> (!$past(hold_w, 1) && !$past(hold_w, 2)));

  // R5
  hold_covers_chk: assert property (@(posedge clk_i) disable iff (!armed)
    hold_w |-> rst_o);

  // R6
  min_width_chk: assert property (@(posedge clk_i) disable iff (!armed)
    $fell(rst_o) |-> $past(rst_o, 2));

  generate
    if (CLAMP_EN) begin : g_clamp_chk
      // R7
      clamp_raw_chk: assert property (@(posedge clk_i) disable iff (!armed)
        req_raw_i |-> (clamp_q_o == CLAMP_VAL));

      // R8
      clamp_after_rst_chk: assert property (@(posedge clk_i) disable iff (!armed)
        ($fell(clamp_act_w) && rst_o) |-> $past(rst_o));

      // R8
      clamp_drop_chk: assert property (@(posedge clk_i) disable iff (!armed)
        $fell(clamp_act_w) |-> !$past(req_raw_i));
    end
  endgenerate
endmodule

bind rstc_top rstc_chk #(
  .W         (DATA_W),
  .CLAMP_EN  (CLAMP_EN),
  .CLAMP_VAL (CLAMP_VAL)
) chk_i (
  .clk_i       (clk_i),
  .req_raw_i   (req_raw_i),
  .rst_o       (rst_o),
  .clamp_q_o   (clamp_q_o),
  .hold_w      (stretch_hold),
  .clamp_act_w (clamp_active)
);

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
  localparam int          MINP = 4;
  localparam int          STR  = 6;
  localparam int          W    = 8;
  localparam logic [W-1:0] CV  = 8'hA5;

  logic         clk = 1'b0;
  logic         raw = 1'b0;
  logic [W-1:0] core = '0;
  logic         rst;
  logic [W-1:0] cq;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstc_top #(
    .MIN_PULSE (MINP),
    .STRETCH   (STR),
    .DATA_W    (W),
    .CLAMP_EN  (1'b1),
    .CLAMP_VAL (CV)
  ) dut_i (
    .clk_i     (clk),
    .req_raw_i (raw),
    .core_q_i  (core),
    .rst_o     (rst),
    .clamp_q_o (cq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Drive a fresh core pattern each cycle so a stuck clamp is visible.
  task automatic step(output int t);
    @(negedge clk);
    t = cyc;
    core = W'(t * 37) ^ 8'h3C;
    #1;
  endtask

  task automatic chk_clamp(input string tag, input bit act_exp);
    chk(tag, int'(cq), act_exp ? int'(CV) : int'(core));
  endtask

  // One isolated request sampled on n edges starting at edge k.
  task automatic run_pulse(input int n);
    int k, t, hi;
    bit acc, er, ea;
    string rt, ct;
    k = cyc + 1;
    hi = 0;
    acc = (n >= MINP);
    raw = 1'b1;
    #1;
    chk_clamp("R7", 1'b1);
    do begin
      step(t);
      er = acc && (t >= k + MINP + 1) && (t < k + n + STR + 3);
      ea = (t < k + n + 2);
      rt = !acc ? "R2" : ((t <= k + n) ? "R3" : "R4");
      ct = (t <= k + n - 1) ? "R7" : (ea ? "R8" : "R9");
      if (rst) hi++;
      chk(rt, int'(rst), int'(er));
      chk_clamp(ct, ea);
      if (t == k + n - 1) raw = 1'b0;
    end while (t < k + n + STR + 6);
    if (acc) chk("R6", hi, n - MINP + STR + 2);
    else     chk("R2", hi, 0);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int t, k1, k2, hi;
    // R1: power-up state and first release.
    #1;
    chk("R1", int'(rst), 1);
    do begin
      step(t);
      chk("R1", int'(rst), int'(t < STR + 4));
    end while (t < STR + 8);
    chk_clamp("R9", 1'b0);

    // R2 and R3/R4/R6: sweep request length across the threshold.
    for (int n = 1; n <= MINP + 4; n++) begin
      run_pulse(n);
    end

    // R2/R7/R8: request high only between two edges.
    @(negedge clk);
    #1 raw = 1'b1;
    #1 chk_clamp("R7", 1'b1);
    #1 raw = 1'b0;
    #1 chk_clamp("R8", 1'b1);
    for (int i = 0; i < 6; i++) begin
      step(t);
      chk("R2", int'(rst), 0);
      chk_clamp("R9", 1'b0);
    end

    // R5: second qualified request during the stretch restarts it.
    k1 = cyc + 1;
    hi = 0;
    raw = 1'b1;
    do begin
      step(t);
      if (t == k1 + MINP) raw = 1'b0;
    end while (t < k1 + MINP + 2);
    k2 = cyc + 1;
    raw = 1'b1;
    do begin
      step(t);
      if (t == k2 + MINP - 1) raw = 1'b0;
      if (rst) hi++;
      chk("R5", int'(rst), int'(t >= k1 + MINP + 1 && t < k2 + MINP + STR + 3));
      chk_clamp("R8", t < k2 + MINP + 2);
    end while (t < k2 + MINP + STR + 6);
    chk("R5", int'(rst), 0);

    // Final idle pass-through.
    step(t);
    chk_clamp("R9", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule